// File: doc/BRIEF.md
# Management-Bus Board Control Register Bank

This block is the responder end of a two-wire serial management bus, acting as the control point of a board. It watches the bus clock and data line and decodes each incoming frame. The frame's 5-bit device field and 5-bit register field are joined into a single 10-bit register address. The block then serves a small bank of 16-bit registers. Some hold fixed identity values. Some hold writable configuration that is also driven onto output ports. One reflects the board's switch inputs. One launches a fixed-length system reset pulse.

The upper region of the map stands for slow storage that is read through a one-word prefetch buffer. A read there returns whatever the buffer held from the previous read of that region, then refills the buffer with the word just addressed. Reading the same location twice in a row therefore yields valid data. On a read frame the responder drives the turnaround bit low and shifts out sixteen data bits. Frames with a malformed start or opcode are ignored without the line ever being driven.

Top module: `brdctl_top`

## Requirements
- R1: A frame is idle ones, a start pair 0 then 1, a 2-bit opcode (10 read, 01 write), then 5 device bits and 5 register bits, MSB first, all sampled on rising bus-clock edges; the register address is device field as bits 9:5 and register field as bits 4:0.
- R2: On a read the line stays undriven through the first turnaround bit. From the rising edge of the second turnaround bit it is driven to 0. After each of the next 16 rising edges it shows the next data bit, MSB first. It is released at the following rising edge.
- R3: Addresses 0x000/0x001 return the low/high halves of the product identifier and 0x002/0x003 the low/high halves of the firmware version; writes to them are ignored.
- R4: Addresses 0x004 (low) and 0x005 (high) form a 32-bit read/write mode setting.
- R5: Addresses 0x006/0x007 are read-only and return the applied mode, also on `modeApplied`; it takes the mode setting only when a reset pulse starts, and is 0 after reset.
- R6: Address 0x008 returns the raw active-low switch pins, the 8-bit bank in bits 7:0 and the 4-bit bank in bits 11:8, upper bits 0.
- R7: Address 0x00B (power), 0x00C/0x00D (peripheral low/high) and 0x00E (indicator) are read/write and drive their output ports, which change only when a write frame completes.
- R8: Writing a word with bit 0 set to 0x00A starts a `resetPulse` of exactly RST_LEN clock cycles. The register reads 0x0001 while the pulse runs and 0x0000 otherwise. Writes with bit 0 clear, and any write during a pulse, have no effect.
- R9: Reads of 0x300..0x303 (board version, silicon version, serial low, serial high) return the prefetch buffer and then load it with the addressed word; the buffer is 0 after reset and writes there are ignored.
- R10: Any other address reads 0x0000 and ignores writes.
- R11: A frame whose opcode is 00 or 11 is neither answered nor written, and the line is never driven.
- R12: After reset the line is undriven, `resetPulse` is low and all configuration outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management bus clock from the host |
| mdioIn | input | 1 | Sensed level of the management data line |
| mdioOut | output | 1 | Value driven on the data line when enabled |
| mdioOe | output | 1 | Drive enable for the data line |
| swLo | input | 8 | 8-bit switch bank, active low |
| swHi | input | 4 | 4-bit switch bank, active low |
| resetPulse | output | 1 | System reset pulse |
| modeApplied | output | 32 | Mode latched at the last reset pulse |
| powerCfg | output | 16 | Power configuration word |
| periCfg | output | 32 | Peripheral configuration word |
| ledCfg | output | 16 | Indicator word |

## Verification
The reset-pulse countdown runs on its own while frame decoding carries on, so a write that completes can land in a cycle in which the pulse is active or ending. The bench provokes this by issuing a mode-setting write, a second reset write and a read of the reset register while the pulse is high. It judges the outcome by counting the pulse's high cycles and rising edges against RST_LEN and a single launch. It also reads back the applied mode, which must still hold the value latched at the pulse start.

// File: rtl/brdctl_pkg.sv
package brdctl_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_ID_LO    = 10'h000;
  localparam logic [ADDR_W-1:0] A_ID_HI    = 10'h001;
  localparam logic [ADDR_W-1:0] A_VER_LO   = 10'h002;
  localparam logic [ADDR_W-1:0] A_VER_HI   = 10'h003;
  localparam logic [ADDR_W-1:0] A_MODE_LO  = 10'h004;
  localparam logic [ADDR_W-1:0] A_MODE_HI  = 10'h005;
  localparam logic [ADDR_W-1:0] A_APPL_LO  = 10'h006;
  localparam logic [ADDR_W-1:0] A_APPL_HI  = 10'h007;
  localparam logic [ADDR_W-1:0] A_SWITCH   = 10'h008;
  localparam logic [ADDR_W-1:0] A_RESET    = 10'h00A;
  localparam logic [ADDR_W-1:0] A_POWER    = 10'h00B;
  localparam logic [ADDR_W-1:0] A_PERI_LO  = 10'h00C;
  localparam logic [ADDR_W-1:0] A_PERI_HI  = 10'h00D;
  localparam logic [ADDR_W-1:0] A_LED      = 10'h00E;
  localparam logic [ADDR_W-1:0] A_SLOW     = 10'h300;

  // strobes from frame control to the register datapath
  typedef struct packed {
    logic              rd;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } bankReq_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_START, S_OP, S_ADDR, S_TURN, S_DATA, S_RELEASE
  } frameSt_t;
endpackage

// File: rtl/brdctl_frame.sv
module brdctl_frame
  import brdctl_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mdc,
  input  logic              mdioIn,
  input  logic [DATA_W-1:0] rdData,
  output bankReq_t          req,
  output logic              mdioOut,
  output logic              mdioOe
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [SYNC_N-1:0] mdcSync, dinSync;
  logic mdcPrev, rise, bitIn;
  frameSt_t st;
  logic [CNT_W-1:0] cnt;
  logic isRead, opHi;
  logic [ADDR_W-1:0] addrSh;
  logic [DATA_W-1:0] dataSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdcSync <= '0;
      dinSync <= '1;
      mdcPrev <= 1'b0;
    end else begin
      mdcSync <= {mdcSync[SYNC_N-2:0], mdc};
      dinSync <= {dinSync[SYNC_N-2:0], mdioIn};
      mdcPrev <= mdcSync[SYNC_N-1];
    end
  end

  assign rise  = mdcSync[SYNC_N-1] & ~mdcPrev;
  assign bitIn = dinSync[SYNC_N-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= S_IDLE;
      cnt     <= '0;
      isRead  <= 1'b0;
      opHi    <= 1'b0;
      addrSh  <= '0;
      dataSh  <= '0;
      req     <= '0;
      mdioOut <= 1'b0;
      mdioOe  <= 1'b0;
    end else begin
      req.rd <= 1'b0;
      req.wr <= 1'b0;
      if (req.rd) dataSh <= rdData;
      if (rise) begin
        case (st)
          S_IDLE:  if (bitIn) st <= S_PRE;
          S_PRE:   if (!bitIn) st <= S_START;
          S_START: begin
            cnt <= '0;
            st  <= bitIn ? S_OP : S_IDLE;
          end
          S_OP: begin
            if (cnt == '0) begin
              opHi <= bitIn;
              cnt  <= cnt + 1'b1;
            end else begin
              cnt <= '0;
              if (opHi != bitIn) begin
                isRead <= opHi;
                st     <= S_ADDR;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_ADDR: begin
            addrSh <= {addrSh[ADDR_W-2:0], bitIn};
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              cnt      <= '0;
              st       <= S_TURN;
              req.addr <= {addrSh[ADDR_W-2:0], bitIn};
              req.rd   <= isRead;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_TURN: begin
            if (cnt == '0) begin
              cnt <= cnt + 1'b1;
            end else begin
              cnt <= '0;
              st  <= S_DATA;
              if (isRead) begin
                mdioOe  <= 1'b1;
                mdioOut <= 1'b0;
              end
            end
          end
          S_DATA: begin
            if (isRead) begin
              mdioOut <= dataSh[DATA_W-1];
              dataSh  <= {dataSh[DATA_W-2:0], 1'b0};
            end else begin
              dataSh  <= {dataSh[DATA_W-2:0], bitIn};
            end
            if (cnt == CNT_W'(DATA_W - 1)) begin
              cnt <= '0;
              if (isRead) begin
                st <= S_RELEASE;
              end else begin
                st        <= S_IDLE;
                req.wr    <= 1'b1;
                req.wdata <= {dataSh[DATA_W-2:0], bitIn};
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_RELEASE: begin
            mdioOe  <= 1'b0;
            mdioOut <= 1'b0;
            st      <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/brdctl_bank.sv
module brdctl_bank
  import brdctl_pkg::*;
#(
  parameter int          RST_LEN    = 2048,
  parameter logic [31:0] PRODUCT_ID = 32'h5A3C_0001,
  parameter logic [31:0] FW_VERSION = 32'h2024_0107,
  parameter logic [15:0] BOARD_VER  = 16'h0102,
  parameter logic [15:0] SOC_VER    = 16'h0300,
  parameter logic [31:0] SERIAL     = 32'h0001_E240
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankReq_t          req,
  input  logic [7:0]        swLo,
  input  logic [3:0]        swHi,
  output logic [DATA_W-1:0] rdData,
  output logic              resetPulse,
  output logic [31:0]       modeApplied,
  output logic [15:0]       powerCfg,
  output logic [31:0]       periCfg,
  output logic [15:0]       ledCfg
);
  localparam int RC_W = $clog2(RST_LEN + 1);

  logic [31:0] modeSetQ;
  logic [DATA_W-1:0] slowBufQ;
  logic [RC_W-1:0] rstCnt;
  logic pulseOn, slowSel;

  assign pulseOn    = rstCnt != '0;
  assign resetPulse = pulseOn;
  assign slowSel    = req.addr[ADDR_W-1:2] == A_SLOW[ADDR_W-1:2];

  function automatic logic [DATA_W-1:0] slowWord(input logic [1:0] idx);
    case (idx)
      2'd0:    return BOARD_VER;
      2'd1:    return SOC_VER;
      2'd2:    return SERIAL[15:0];
      default: return SERIAL[31:16];
    endcase
  endfunction

  always_comb begin
    rdData = '0;
    if (slowSel) begin
      rdData = slowBufQ;
    end else begin
      case (req.addr)
        A_ID_LO:   rdData = PRODUCT_ID[15:0];
        A_ID_HI:   rdData = PRODUCT_ID[31:16];
        A_VER_LO:  rdData = FW_VERSION[15:0];
        A_VER_HI:  rdData = FW_VERSION[31:16];
        A_MODE_LO: rdData = modeSetQ[15:0];
        A_MODE_HI: rdData = modeSetQ[31:16];
        A_APPL_LO: rdData = modeApplied[15:0];
        A_APPL_HI: rdData = modeApplied[31:16];
        A_SWITCH:  rdData = {4'h0, swHi, swLo};
        A_RESET:   rdData = {15'h0, pulseOn};
        A_POWER:   rdData = powerCfg;
        A_PERI_LO: rdData = periCfg[15:0];
        A_PERI_HI: rdData = periCfg[31:16];
        A_LED:     rdData = ledCfg;
        default:   rdData = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSetQ    <= '0;
      modeApplied <= '0;
      powerCfg    <= '0;
      periCfg     <= '0;
      ledCfg      <= '0;
      slowBufQ    <= '0;
      rstCnt      <= '0;
    end else begin
      if (pulseOn) rstCnt <= rstCnt - 1'b1;
      if (req.rd && slowSel) slowBufQ <= slowWord(req.addr[1:0]);
      if (req.wr) begin
        case (req.addr)
          A_MODE_LO: modeSetQ[15:0]  <= req.wdata;
          A_MODE_HI: modeSetQ[31:16] <= req.wdata;
          A_POWER:   powerCfg        <= req.wdata;
          A_PERI_LO: periCfg[15:0]   <= req.wdata;
          A_PERI_HI: periCfg[31:16]  <= req.wdata;
          A_LED:     ledCfg          <= req.wdata;
          A_RESET: begin
            if (req.wdata[0] && !pulseOn) begin
              rstCnt      <= RC_W'(RST_LEN);
              modeApplied <= modeSetQ;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/brdctl_top.sv
module brdctl_top
  import brdctl_pkg::*;
#(
  parameter int          RST_LEN    = 2048,
  parameter int          SYNC_N     = 2,
  parameter logic [31:0] PRODUCT_ID = 32'h5A3C_0001,
  parameter logic [31:0] FW_VERSION = 32'h2024_0107,
  parameter logic [15:0] BOARD_VER  = 16'h0102,
  parameter logic [15:0] SOC_VER    = 16'h0300,
  parameter logic [31:0] SERIAL     = 32'h0001_E240
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mdc,
  input  logic        mdioIn,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic [7:0]  swLo,
  input  logic [3:0]  swHi,
  output logic        resetPulse,
  output logic [31:0] modeApplied,
  output logic [15:0] powerCfg,
  output logic [31:0] periCfg,
  output logic [15:0] ledCfg
);
  bankReq_t bankReq;
  logic [DATA_W-1:0] rdData;

  brdctl_frame #(.SYNC_N(SYNC_N)) u_frame (
    .clk(clk), .rstN(rstN), .mdc(mdc), .mdioIn(mdioIn), .rdData(rdData),
    .req(bankReq), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  brdctl_bank #(
    .RST_LEN(RST_LEN), .PRODUCT_ID(PRODUCT_ID), .FW_VERSION(FW_VERSION),
    .BOARD_VER(BOARD_VER), .SOC_VER(SOC_VER), .SERIAL(SERIAL)
  ) u_bank (
    .clk(clk), .rstN(rstN), .req(bankReq), .swLo(swLo), .swHi(swHi),
    .rdData(rdData), .resetPulse(resetPulse), .modeApplied(modeApplied),
    .powerCfg(powerCfg), .periCfg(periCfg), .ledCfg(ledCfg)
  );
endmodule

// File: rtl/brdctl_chk.sv
module brdctl_chk #(
  parameter int RST_LEN = 2048
) (
  input logic        clk,
  input logic        rstN,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic        resetPulse,
  input logic [31:0] modeApplied,
  input logic [63:0] cfgBus,
  input logic        bankWr
);
  localparam int PC_W = $clog2(RST_LEN + 1) + 1;
  logic [PC_W-1:0] pulseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseCnt <= '0;
    else if (resetPulse) pulseCnt <= pulseCnt + 1'b1;
    else pulseCnt <= '0;
  end

  // R2: turnaround starts low and the line is quiet while undriven
  assert_turn_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdioOe) |-> !mdioOut);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !mdioOe |-> !mdioOut);
  // R5: applied mode moves only when a pulse starts
  assert_applied_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(resetPulse) |-> $stable(modeApplied));
  // R7: configuration outputs move only after a completed write
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !bankWr |=> $stable(cfgBus));
  // R8: pulse width is exactly RST_LEN cycles
  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetPulse) |-> pulseCnt == PC_W'(RST_LEN));
  assert_pulse_max_R8: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |-> pulseCnt < PC_W'(RST_LEN));
endmodule

bind brdctl_top brdctl_chk #(.RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .resetPulse(resetPulse), .modeApplied(modeApplied),
  .cfgBus({powerCfg, periCfg, ledCfg}), .bankWr(bankReq.wr)
);

// File: tb/sim_brdctl_top.sv
`timescale 1ns/1ps
module sim_brdctl_top;
  localparam int RST_LEN = 2048;
  localparam int HALF = 6;
  localparam logic [31:0] PID = 32'h5A3C_0001, FWV = 32'h2024_0107, SER = 32'h0001_E240;
  localparam logic [15:0] BVER = 16'h0102, SVER = 16'h0300;

  logic clk = 0, rstN = 0, mdc = 0, mDrv = 0, mVal = 1;
  logic [7:0] swLo = 8'hFF;
  logic [3:0] swHi = 4'hF;
  logic mdioOut, mdioOe, resetPulse, line;
  logic [31:0] modeApplied, periCfg;
  logic [15:0] powerCfg, ledCfg;

  always #4 clk = ~clk;
  assign line = mdioOe ? mdioOut : (mDrv ? mVal : 1'b1);

  brdctl_top #(.RST_LEN(RST_LEN)) u0 (
    .clk(clk), .rstN(rstN), .mdc(mdc), .mdioIn(line), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .swLo(swLo), .swHi(swHi), .resetPulse(resetPulse),
    .modeApplied(modeApplied), .powerCfg(powerCfg), .periCfg(periCfg), .ledCfg(ledCfg)
  );

  int nChk = 0, nBad = 0, pulseCycles = 0, pulseRises = 0;
  logic prevPulse = 0, oeSeen = 0, done = 0;
  // bench model
  logic [31:0] mMode = 0, mAppl = 0, mPeri = 0;
  logic [15:0] mPwr = 0, mLed = 0, mSlow = 0;
  logic mRstOn = 0;

  always @(posedge clk) begin
    if (resetPulse) pulseCycles++;
    if (resetPulse && !prevPulse) pulseRises++;
    prevPulse <= resetPulse;
    if (mdioOe) oeSeen <= 1'b1;
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic mbit(input logic v, input logic drv);
    @(negedge clk); mdc = 0; mDrv = drv; mVal = v;
    repeat (HALF - 1) @(negedge clk);
    mdc = 1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic header(input logic [1:0] op, input logic [9:0] a);
    repeat (6) mbit(1, 1);
    mbit(0, 1); mbit(1, 1);
    mbit(op[1], 1); mbit(op[0], 1);
    for (int i = 9; i >= 0; i--) mbit(a[i], 1);
  endtask

  function automatic logic [15:0] slowVal(input logic [1:0] i);
    case (i)
      2'd0: return BVER;
      2'd1: return SVER;
      2'd2: return SER[15:0];
      default: return SER[31:16];
    endcase
  endfunction

  function automatic logic [15:0] expRead(input logic [9:0] a);
    if (a[9:2] == 8'hC0) return mSlow;
    case (a)
      10'h000: return PID[15:0];
      10'h001: return PID[31:16];
      10'h002: return FWV[15:0];
      10'h003: return FWV[31:16];
      10'h004: return mMode[15:0];
      10'h005: return mMode[31:16];
      10'h006: return mAppl[15:0];
      10'h007: return mAppl[31:16];
      10'h008: return {4'h0, swHi, swLo};
      10'h00A: return {15'h0, mRstOn};
      10'h00B: return mPwr;
      10'h00C: return mPeri[15:0];
      10'h00D: return mPeri[31:16];
      10'h00E: return mLed;
      default: return 16'h0;
    endcase
  endfunction

  task automatic doRead(input logic [9:0] a, input string tag);
    logic [15:0] got, exp;
    exp = expRead(a);
    if (a[9:2] == 8'hC0) mSlow = slowVal(a[1:0]);
    header(2'b10, a);
    mbit(1, 0);
    chk(!mdioOe, "R2 turn1 undriven", 64'(mdioOe), 0);
    mbit(1, 0);
    chk(mdioOe && !line, "R2 turn2 low", {mdioOe, line}, 64'h2);
    got = '0;
    for (int i = 0; i < 16; i++) begin mbit(1, 0); got = {got[14:0], line}; end
    mbit(1, 0);
    chk(!mdioOe, "R2 release", 64'(mdioOe), 0);
    chk(got == exp, tag, 64'(got), 64'(exp));
  endtask

  task automatic doWrite(input logic [9:0] a, input logic [15:0] d);
    header(2'b01, a);
    mbit(1, 1); mbit(0, 1);
    for (int i = 15; i >= 0; i--) mbit(d[i], 1);
    mbit(1, 0);
    case (a)
      10'h004: mMode[15:0] = d;
      10'h005: mMode[31:16] = d;
      10'h00B: mPwr = d;
      10'h00C: mPeri[15:0] = d;
      10'h00D: mPeri[31:16] = d;
      10'h00E: mLed = d;
      default: ;
    endcase
  endtask

  task automatic checkOuts(input string tag);
    chk(powerCfg == mPwr, tag, 64'(powerCfg), 64'(mPwr));
    chk(periCfg == mPeri, tag, 64'(periCfg), 64'(mPeri));
    chk(ledCfg == mLed, tag, 64'(ledCfg), 64'(mLed));
    chk(modeApplied == mAppl, tag, 64'(modeApplied), 64'(mAppl));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  initial begin
    logic [9:0] a;
    logic [15:0] d;
    int r;
    void'($urandom(32'd20240517));
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!mdioOe && !resetPulse, "R12 line/pulse idle", {mdioOe, resetPulse}, 0);
    checkOuts("R12 outputs zero");

    // R1 address join: device 8 reg 0x0B is unmapped, plain 0x00B is power
    doWrite(10'h00B, 16'hA5C3);
    doWrite(10'h10B, 16'h1111);
    chk(powerCfg == 16'hA5C3, "R1 R10 device field decoded", 64'(powerCfg), 64'hA5C3);
    doRead(10'h00B, "R1 R7 power readback");
    doRead(10'h10B, "R10 unmapped reads zero");
    // R3 identity read-only
    doWrite(10'h000, 16'hDEAD);
    doRead(10'h000, "R3 product low");
    doRead(10'h003, "R3 version high");
    // R4 R5 mode set, applied untouched
    doWrite(10'h004, 16'h1234);
    doWrite(10'h005, 16'hABCD);
    doWrite(10'h006, 16'hFFFF);
    doRead(10'h005, "R4 mode high");
    doRead(10'h006, "R5 applied still zero");
    // R6 switches
    swLo = 8'h5A; swHi = 4'h9;
    doRead(10'h008, "R6 switch word");
    // R9 prefetch buffer
    doRead(10'h301, "R9 first read stale");
    doRead(10'h301, "R9 repeat read valid");
    doRead(10'h303, "R9 other addr stale");
    doWrite(10'h302, 16'h7777);
    doRead(10'h303, "R9 repeat valid after ignored write");
    // R11 bad opcodes
    oeSeen = 0;
    header(2'b11, 10'h3FF);
    for (int i = 0; i < 18; i++) mbit(1, 1);
    header(2'b00, 10'h3FF);
    for (int i = 0; i < 18; i++) mbit(1, 1);
    mbit(1, 0);
    chk(!oeSeen, "R11 no drive on bad opcode", 64'(oeSeen), 0);
    checkOuts("R11 nothing written");
    // R8 reset pulse; bit0 clear does nothing
    doWrite(10'h00A, 16'hFFFE);
    chk(pulseRises == 0, "R8 bit0 clear no pulse", 64'(pulseRises), 0);
    doWrite(10'h00A, 16'h0001);
    mRstOn = 1; mAppl = mMode;
    chk(resetPulse, "R8 pulse running", 64'(resetPulse), 1);
    doWrite(10'h004, 16'h5555);
    doWrite(10'h00A, 16'h0001);
    doRead(10'h00A, "R8 reads one during pulse");
    chk(modeApplied == 32'hABCD1234, "R5 applied latched at pulse", 64'(modeApplied), 64'hABCD1234);
    while (resetPulse) @(negedge clk);
    mRstOn = 0;
    chk(pulseCycles == RST_LEN, "R8 pulse width", 64'(pulseCycles), 64'(RST_LEN));
    chk(pulseRises == 1, "R8 retrigger ignored", 64'(pulseRises), 1);
    doRead(10'h00A, "R8 reads zero after pulse");
    doRead(10'h007, "R5 applied high");

    // random mix (reset register excluded)
    for (int n = 0; n < 110; n++) begin
      r = int'($urandom % 21);
      if (r <= 14) a = (r == 10) ? 10'h009 : 10'(r);
      else if (r <= 18) a = 10'h300 + 10'(r - 15);
      else if (r == 19) a = 10'h1F5;
      else a = 10'h30C;
      d = 16'($urandom);
      if ($urandom % 8 == 0) begin swLo = 8'($urandom); swHi = 4'($urandom); end
      if ($urandom % 2 == 0) begin
        doWrite(a, d);
        checkOuts("R7 outputs after random write");
      end else begin
        doRead(a, "R4 R7 R9 R10 random read");
      end
    end
    done = 1;
    summary();
  end
endmodule